// File: doc/BRIEF.md
# Interrupt Cause Register with Conditional Clear-on-Read

This block collects hardware interrupt causes into one cause register and drives a single level interrupt toward the host. Each cycle, one-cycle event pulses set cause bits. A mask register selects which causes may raise the interrupt. The top bit of the cause register is a summary flag. It is set when an event arrives on a cause that the mask currently enables. A small request/response register bus gives software access to the cause register, the mask-set port, the mask-clear port and an auto-mask select register.

The read of the cause register is the central feature. The bus returns the value the register held before the read. The same read may then wipe the whole register, depending on four things: the mask state, the summary flag, the auto-mask enable input and the per-vector signalling mode input. When auto-mask applies, the read also drops the mask bits chosen by the auto-mask select register.

A driver uses the block as follows. It enables causes through the mask-set port and takes the interrupt. It reads the cause register once to learn and acknowledge the causes. If the read did not clear them, it clears causes explicitly by writing 1s to them.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, the cause register, the mask and the auto-mask select all read as zero, and `irq_o` is low.
- R2: An event pulse on cause input bit k sets cause bit k on the next clock edge. Cause bit 31 (the summary flag) is set on the same edge when any pulsed cause is enabled in the mask at that time.
- R3: The bus addresses are 0 = cause, 1 = mask set, 2 = mask clear, 3 = auto-mask select. A write to address 1 ORs the low 31 data bits into the mask. A write to address 2 clears the mask bits at the positions of its 1s. A read of address 1 returns the mask zero-extended. A read of address 2 returns zero.
- R4: `irq_o` is high exactly while some cause bit 30..0 is set and also enabled in the mask.
- R5: A read returns data with `rsp_valid_o` high one cycle after the request. For address 0, the data is the cause value before any clear caused by that read.
- R6: While `msix_mode_i` is low, every read of the cause register clears the whole register.
- R7: A read of the cause register while the mask is all zeros clears the whole register.
- R8: A read of the cause register with the summary flag set and `automask_en_i` high clears the whole register. It also clears the mask bits selected by the auto-mask select register.
- R9: A read of the cause register with the summary flag set and a nonzero overlap between the cause bits and the mask clears the whole register, even when `automask_en_i` is low.
- R10: In per-vector mode with a nonzero mask, a cause read leaves the register unchanged if the summary flag is clear, or if the flag is set but auto-mask is off and no cause overlaps the mask. For example, with mask 0xAA and causes 0x55, the causes stay.
- R11: An event arriving in the same cycle as a clearing read survives the clear, together with the summary flag it earns.
- R12: A write to address 0 clears the cause bits, including the summary flag, at the positions of its 1s. Address 3 is an ordinary read/write register over bits 30..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msix_mode_i | input | 1 | High selects per-vector signalling mode |
| automask_en_i | input | 1 | Enables mask auto-clear on a cause read |
| cause_evt_i | input | 31 | One-cycle cause event pulses |
| req_valid_i | input | 1 | Bus request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | Register address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_data_o | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt output |

## Verification
A wrong clear decision shows at the ports on the very next cause read, one cycle later. That read returns either leftover causes or a register emptied too early. A mask that was wrongly auto-cleared, or not cleared, shows in `irq_o` on the next clock edge and in the next mask read. A summary flag that is set when it should not be, or missing, only shows through the clear decisions it changes. For that reason, every directed case reads the cause register a second time after the read under test.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  typedef enum logic [1:0] {
    ADR_CAUSE = 2'd0,
    ADR_MSET  = 2'd1,
    ADR_MCLR  = 2'd2,
    ADR_AUTO  = 2'd3
  } irq_addr_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_cause_pkg::*;
(
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] req_addr,
  output logic       rd_any,
  output logic       rd_cause,
  output logic       wr_cause,
  output logic       wr_mset,
  output logic       wr_mclr,
  output logic       wr_auto
);
  irq_addr_e addr;
  logic      do_wr;

  always_comb begin
    addr     = irq_addr_e'(req_addr);
    do_wr    = req_valid & req_write;
    rd_any   = req_valid & ~req_write;
    rd_cause = rd_any & (addr == ADR_CAUSE);
    wr_cause = do_wr & (addr == ADR_CAUSE);
    wr_mset  = do_wr & (addr == ADR_MSET);
    wr_mclr  = do_wr & (addr == ADR_MCLR);
    wr_auto  = do_wr & (addr == ADR_AUTO);
  end
endmodule

// File: rtl/irq_clear_policy.sv
module irq_clear_policy #(
  parameter int N_CAUSE = 31
) (
  input  logic               rd_cause,
  input  logic               msix_mode,
  input  logic               automask_en,
  input  logic               summary,
  input  logic [N_CAUSE-1:0] cause,
  input  logic [N_CAUSE-1:0] mask,
  input  logic [N_CAUSE-1:0] automask_sel,
  output logic               clr_all,
  output logic [N_CAUSE-1:0] mask_drop
);
  logic overlap;
  logic mask_empty;
  logic auto_hit;

  always_comb begin
    overlap    = |(cause & mask);
    mask_empty = (mask == '0);
    auto_hit   = summary & automask_en;
    clr_all    = rd_cause & (mask_empty | ~msix_mode | auto_hit | (summary & overlap));
    mask_drop  = (rd_cause & auto_hit) ? automask_sel : '0;
  end
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int N_CAUSE = 31,
  localparam int WIDTH  = N_CAUSE + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CAUSE-1:0] evt,
  input  logic [N_CAUSE-1:0] mask,
  input  logic               clr_all,
  input  logic               wr_w1c,
  input  logic [WIDTH-1:0]   wdata,
  output logic [WIDTH-1:0]   cause_q
);
  logic [N_CAUSE-1:0] low_d;
  logic               sum_d;
  logic               en;
  logic [WIDTH-1:0]   w1c;

  always_comb begin
    w1c   = wr_w1c ? wdata : '0;
    en    = clr_all | wr_w1c | (|evt);
    low_d = (clr_all ? '0 : (cause_q[N_CAUSE-1:0] & ~w1c[N_CAUSE-1:0])) | evt;
    sum_d = (clr_all ? 1'b0 : (cause_q[WIDTH-1] & ~w1c[WIDTH-1])) | (|(evt & mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cause_q <= '0;
    else if (en) cause_q <= {sum_d, low_d};
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N_CAUSE = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mset,
  input  logic               wr_mclr,
  input  logic               wr_auto,
  input  logic [N_CAUSE-1:0] wdata,
  input  logic [N_CAUSE-1:0] mask_drop,
  output logic [N_CAUSE-1:0] mask_q,
  output logic [N_CAUSE-1:0] auto_q
);
  logic [N_CAUSE-1:0] mask_d;
  logic               mask_en;

  always_comb begin
    mask_en = wr_mset | wr_mclr | (|mask_drop);
    mask_d  = (mask_q | (wr_mset ? wdata : '0)) & ~(wr_mclr ? wdata : '0) & ~mask_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       auto_q <= '0;
    else if (wr_auto) auto_q <= wdata;
  end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int N_CAUSE = 31,
  localparam int WIDTH  = N_CAUSE + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msix_mode_i,
  input  logic               automask_en_i,
  input  logic [N_CAUSE-1:0] cause_evt_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [1:0]         req_addr_i,
  input  logic [WIDTH-1:0]   req_wdata_i,
  output logic               rsp_valid_o,
  output logic [WIDTH-1:0]   rsp_data_o,
  output logic               irq_o
);
  logic               rd_any, rd_cause, wr_cause, wr_mset, wr_mclr, wr_auto;
  logic               clr_all;
  logic [N_CAUSE-1:0] mask_drop;
  logic [WIDTH-1:0]   icr_q;
  logic [N_CAUSE-1:0] ims_q;
  logic [N_CAUSE-1:0] iam_q;
  logic [WIDTH-1:0]   rd_mux;

  irq_bus_decode u_dec (
    .req_valid (req_valid_i),
    .req_write (req_write_i),
    .req_addr  (req_addr_i),
    .rd_any    (rd_any),
    .rd_cause  (rd_cause),
    .wr_cause  (wr_cause),
    .wr_mset   (wr_mset),
    .wr_mclr   (wr_mclr),
    .wr_auto   (wr_auto)
  );

  irq_clear_policy #(.N_CAUSE(N_CAUSE)) u_pol (
    .rd_cause     (rd_cause),
    .msix_mode    (msix_mode_i),
    .automask_en  (automask_en_i),
    .summary      (icr_q[WIDTH-1]),
    .cause        (icr_q[N_CAUSE-1:0]),
    .mask         (ims_q),
    .automask_sel (iam_q),
    .clr_all      (clr_all),
    .mask_drop    (mask_drop)
  );

  irq_cause_reg #(.N_CAUSE(N_CAUSE)) u_icr (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (cause_evt_i),
    .mask    (ims_q),
    .clr_all (clr_all),
    .wr_w1c  (wr_cause),
    .wdata   (req_wdata_i),
    .cause_q (icr_q)
  );

  irq_mask_reg #(.N_CAUSE(N_CAUSE)) u_msk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mset   (wr_mset),
    .wr_mclr   (wr_mclr),
    .wr_auto   (wr_auto),
    .wdata     (req_wdata_i[N_CAUSE-1:0]),
    .mask_drop (mask_drop),
    .mask_q    (ims_q),
    .auto_q    (iam_q)
  );

  always_comb begin
    unique case (irq_addr_e'(req_addr_i))
      ADR_CAUSE: rd_mux = icr_q;
      ADR_MSET:  rd_mux = {1'b0, ims_q};
      ADR_AUTO:  rd_mux = {1'b0, iam_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_o <= 1'b0;
    else        rsp_valid_o <= rd_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_data_o <= '0;
    else if (rd_any) rsp_data_o <= rd_mux;
  end

  assign irq_o = |(icr_q[N_CAUSE-1:0] & ims_q);
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk #(
  parameter int N_CAUSE = 31,
  localparam int WIDTH  = N_CAUSE + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msix_mode_i,
  input logic               automask_en_i,
  input logic [N_CAUSE-1:0] cause_evt_i,
  input logic               req_valid_i,
  input logic               req_write_i,
  input logic [1:0]         req_addr_i,
  input logic [WIDTH-1:0]   req_wdata_i,
  input logic               rsp_valid_o,
  input logic [WIDTH-1:0]   rsp_data_o,
  input logic [WIDTH-1:0]   icr_q,
  input logic [N_CAUSE-1:0] ims_q,
  input logic [N_CAUSE-1:0] iam_q
);
  logic rd_c, sum, ovl, keep;
  always_comb begin
    rd_c = req_valid_i & ~req_write_i & (req_addr_i == 2'd0);
    sum  = icr_q[WIDTH-1];
    ovl  = |(icr_q[N_CAUSE-1:0] & ims_q);
    keep = rd_c & msix_mode_i & (ims_q != '0) & ~(sum & (automask_en_i | ovl));
  end

  assert_rd_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_c |=> (rsp_valid_o && rsp_data_o == $past(icr_q)));

  assert_flat_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !msix_mode_i) |=> (icr_q[N_CAUSE-1:0] == $past(cause_evt_i)));

  assert_auto_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && sum && automask_en_i) |=> ((ims_q & $past(iam_q)) == '0));

  assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    keep |=> (icr_q[N_CAUSE-1:0] == ($past(icr_q[N_CAUSE-1:0]) | $past(cause_evt_i))));

  assert_mclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && req_addr_i == 2'd2) |=> ((ims_q & $past(req_wdata_i[N_CAUSE-1:0])) == '0));

  assert_evt_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_evt_i != '0) |=> ((icr_q[N_CAUSE-1:0] & $past(cause_evt_i)) == $past(cause_evt_i)));
endmodule

bind irq_cause_ctrl irq_cause_chk #(.N_CAUSE(N_CAUSE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .msix_mode_i   (msix_mode_i),
  .automask_en_i (automask_en_i),
  .cause_evt_i   (cause_evt_i),
  .req_valid_i   (req_valid_i),
  .req_write_i   (req_write_i),
  .req_addr_i    (req_addr_i),
  .req_wdata_i   (req_wdata_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_data_o    (rsp_data_o),
  .icr_q         (icr_q),
  .ims_q         (ims_q),
  .iam_q         (iam_q)
);

// File: tb/sim_irq_cause_ctrl.sv
`timescale 1ns/1ps
module sim_irq_cause_ctrl;
  logic        clk;
  logic        rst_n;
  logic        msix, am;
  logic [30:0] evt;
  logic        vld, wr;
  logic [1:0]  adr;
  logic [31:0] wd;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [31:0] m_icr;
  logic [30:0] m_ims, m_iam;

  irq_cause_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .msix_mode_i(msix), .automask_en_i(am),
    .cause_evt_i(evt), .req_valid_i(vld), .req_write_i(wr), .req_addr_i(adr),
    .req_wdata_i(wd), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .irq_o(irq)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one bus cycle: drive at negedge, model the result, check at next negedge
  task automatic step(string tag, bit w, bit r, logic [1:0] a, logic [31:0] d, logic [30:0] ev);
    logic [31:0] exp_rd;
    logic        sum, ov, rdc, clr;
    logic [30:0] drop, low;
    logic        s;
    vld = w | r; wr = w; adr = a; wd = d; evt = ev;
    case (a)
      2'd0: exp_rd = m_icr;
      2'd1: exp_rd = {1'b0, m_ims};
      2'd3: exp_rd = {1'b0, m_iam};
      default: exp_rd = 32'h0;
    endcase
    sum  = m_icr[31];
    ov   = |(m_icr[30:0] & m_ims);
    rdc  = r && (a == 2'd0);
    clr  = rdc && ((m_ims == '0) || !msix || (sum && am) || (sum && ov));
    drop = (rdc && sum && am) ? m_iam : '0;
    low  = (clr ? 31'h0 : (m_icr[30:0] & ~((w && a == 2'd0) ? d[30:0] : 31'h0))) | ev;
    s    = (clr ? 1'b0 : (sum & ~(w && a == 2'd0 && d[31]))) | (|(ev & m_ims));
    m_icr = {s, low};
    m_ims = (m_ims | ((w && a == 2'd1) ? d[30:0] : 31'h0)) & ~((w && a == 2'd2) ? d[30:0] : 31'h0) & ~drop;
    if (w && a == 2'd3) m_iam = d[30:0];
    @(posedge clk);
    @(negedge clk);
    vld = 0; wr = 0; evt = '0;
    check({tag, " valid"}, {31'h0, rsp_valid}, {31'h0, r});
    if (r) check(tag, rsp_data, exp_rd);
    check("R4 irq", {31'h0, irq}, {31'h0, |(m_icr[30:0] & m_ims)});
  endtask

  task automatic rd_(string tag, logic [1:0] a);        step(tag, 0, 1, a, 0, 0); endtask
  task automatic wr_(string tag, logic [1:0] a, logic [31:0] d); step(tag, 1, 0, a, d, 0); endtask
  task automatic ev_(string tag, logic [30:0] e);       step(tag, 0, 0, 0, 0, e); endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    rst_n = 0; msix = 1; am = 0; evt = '0; vld = 0; wr = 0; adr = 0; wd = 0;
    m_icr = '0; m_ims = '0; m_iam = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd_("R1 cause", 0); rd_("R1 mask", 1); rd_("R1 auto", 3);
    // mask set / clear
    wr_("R3 set", 1, 32'hAA); rd_("R3 mask", 1);
    wr_("R3 clr", 2, 32'h0A); rd_("R3 mask", 1); rd_("R3 mclr read", 2);
    // causes outside the mask, no summary
    ev_("R2", 31'h55); rd_("R5 pre", 0); rd_("R10 kept", 0);
    wr_("R3 set", 1, 32'h0A);
    rd_("R10 0xAA/0x55 kept", 0); rd_("R10 kept again", 0);
    // summary + overlap, auto-mask off
    ev_("R2 summary", 31'h02); rd_("R9 read", 0); rd_("R9 cleared", 0);
    // overlap without summary
    ev_("R2", 31'h04); wr_("R3 set", 1, 32'h04);
    rd_("R10 no summary", 0); rd_("R10 kept", 0);
    wr_("R12 w1c", 0, 32'h4); rd_("R12 w1c", 0);
    // auto-mask
    wr_("R12 iam", 3, 32'h0F); rd_("R12 iam", 3);
    am = 1;
    ev_("R2", 31'h02); rd_("R8 read", 0); rd_("R8 cleared", 0); rd_("R8 mask dropped", 1);
    am = 0;
    // empty mask
    wr_("R3 clr all", 2, 32'h7FFFFFFF);
    ev_("R2", 31'h03); rd_("R7 read", 0); rd_("R7 cleared", 0);
    // non per-vector mode
    msix = 0; wr_("R3 set", 1, 32'hFF);
    ev_("R2", 31'h100); rd_("R6 read", 0); rd_("R6 cleared", 0);
    // event same cycle as clearing read
    ev_("R2", 31'h10);
    step("R11 read", 0, 1, 0, 0, 31'h20); rd_("R11 survives", 0);
    wr_("R12 w1c sum", 0, 32'h80000000); rd_("R12 w1c sum", 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [30:0] e;
      bit          w;
      if ($urandom % 64 == 0) msix = $urandom;
      if ($urandom % 64 == 0) am = $urandom;
      e = ($urandom % 4 == 0) ? (31'(1) << ($urandom % 31)) : 31'h0;
      w = $urandom;
      if ($urandom % 3 == 0) step("R2/R5 idle", 0, 0, 0, 0, e);
      else step("R5 random", w, !w, 2'($urandom), w ? ($urandom & $urandom) : 0, e);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule